// File: doc/BRIEF.md
# Twelve-Pin GPIO Controller with Latched Level Interrupts

This block gives software control of a set of general-purpose pins through a small word-addressed register bus. Each pin has an output-data bit and an output-enable bit, which go straight to the pad as a data signal and a separate drive-enable signal. Each pin's input is resynchronised to the block clock. Software reads the synchronised value back.

The synchronised input also feeds a per-pin level detector. Its active polarity (high or low) is chosen by one bit in one of two type registers. When the active level is seen, the pin's status bit is set and stays set until software writes a one to it. Writing a one while the level is still present clears the bit for exactly one cycle, after which it sets again. The status bits are masked by an interrupt-enable register and ORed into one active-high interrupt line. A further 32-bit register is plain storage for the pin-mux setting and has no effect on the logic here.

Register word offsets: 0x00 output data, 0x04 output enable, 0x08 input value (read-only), 0x0C interrupt status (write one to clear), 0x10 polarity for pins 0..7, 0x14 interrupt enable, 0x18 polarity for pins 8..11, 0x1C mux storage.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe`, `pin_out` and `irq` are 0.
- R2: Output data (0x00) and output enable (0x04) hold bits 11:0 of a write. `pin_out` equals the data bits and `pin_oe` equals the enable bits, and both change only on a register write.
- R3: A new `pin_in` value is readable at 0x08 after the second rising edge that samples it, and not after the first.
- R4: The polarity of pin n is bit 4*(n mod 8) of 0x10 (pins 0..7) or 0x18 (pins 8..11). 0 means the active level is high and 1 means it is low. Only those bits are stored; the others read 0.
- R5: A pin's status bit (bit n of 0x0C) sets on the edge after its synchronised input is at the active level, and stays set after the level goes away.
- R6: Writing 0x0C clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R7: If a status bit is cleared while its pin is still at the active level, it reads 0 after the clearing edge and 1 again after the next edge.
- R8: `irq` is 1 exactly when some pin has both its status bit and its enable bit (bit n of 0x14) set. `irq` holds while no register is written.
- R9: The mux register at 0x1C stores and returns all 32 bits and changes no pin output.
- R10: Reads of addresses that are undefined (not word aligned, or at 0x20 or above) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 12 | Asynchronous pin inputs |
| pin_out | output | 12 | Pad output data |
| pin_oe | output | 12 | Pad drive enable, 1 = drive |
| irq | output | 1 | Combined active-high interrupt |

## Verification
The collision that matters is a software clear of a status bit in the same cycle that the detector still sees the pin's active level. The bench holds a pin at its active level with the interrupt unmasked and then writes a one to that status bit. It then samples status and `irq` once just after the clearing edge, expecting 0, and once after the following edge, expecting 1 again. A second, milder overlap is a clear of one bit while other bits stay set, which is judged by reading back the whole status word.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
   // Word index decoded from byte address bits [4:2]; the order is the map.
   typedef enum logic [2:0] {
      W_DOUT   = 3'd0,
      W_OEN    = 3'd1,
      W_PIN    = 3'd2,
      W_STAT   = 3'd3,
      W_POL_LO = 3'd4,
      W_IEN    = 3'd5,
      W_POL_HI = 3'd6,
      W_MUX    = 3'd7
   } reg_word_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_lvl_cell.sv
module gpio_lvl_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   input  logic pol_low,
   input  logic clr,
   output logic stat
);
   logic act;
   logic stat_q;

   assign act = lvl_in ^ pol_low;

   // clear wins for one cycle; a still-active level sets the bit the next edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stat_q <= 1'b0;
      else if (clr)  stat_q <= 1'b0;
      else           stat_q <= stat_q | act;
   end

   assign stat = stat_q;

   // R6
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !stat_q);
   // R5
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !clr) |=> stat_q);
   // R7
   level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !clr) |=> stat_q);
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
   import gpio_lvl_pkg::*;
#(
   parameter int NPINS  = 12,
   parameter int DW     = 32,
   parameter int AW     = 8,
   parameter int GRP    = 8,
   parameter int STRIDE = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_we,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             irq
);
   localparam int NGRP = (NPINS + GRP - 1) / GRP;

   generate
      if (NGRP > 2) begin : g_bad_groups
         $error("gpio_lvl_ctrl: only two polarity registers exist");
      end
      if (GRP * STRIDE > DW) begin : g_bad_stride
         $error("gpio_lvl_ctrl: polarity field does not fit the word");
      end
      if (NPINS > DW || AW < 6) begin : g_bad_width
         $error("gpio_lvl_ctrl: width parameters out of range");
      end
   endgenerate

   logic [NPINS-1:0] dout_q, oen_q, ien_q, pol_q;
   logic [DW-1:0]    mux_q;
   logic [NPINS-1:0] in_sync, stat, clr_vec;
   logic             addr_ok, wr;
   reg_word_e        word;
   logic [DW-1:0]    pol_lo_view, pol_hi_view;

   // ---- address decode ----
   assign addr_ok = (bus_addr[1:0] == 2'b00) && (bus_addr[AW-1:5] == '0);
   assign word    = reg_word_e'(bus_addr[4:2]);
   assign wr      = bus_we && addr_ok;

   // ---- input synchroniser ----
   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(pin_in),
      .q_sync (in_sync)
   );

   // ---- plain storage registers ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         oen_q  <= '0;
         ien_q  <= '0;
         mux_q  <= '0;
      end else if (wr) begin
         case (word)
            W_DOUT:  dout_q <= bus_wdata[NPINS-1:0];
            W_OEN:   oen_q  <= bus_wdata[NPINS-1:0];
            W_IEN:   ien_q  <= bus_wdata[NPINS-1:0];
            W_MUX:   mux_q  <= bus_wdata;
            default: ;
         endcase
      end
   end

   // ---- polarity bits, one per pin at a fixed stride ----
   generate
      for (genvar n = 0; n < NPINS; n++) begin : g_pol
         localparam int BITP = STRIDE * (n % GRP);
         localparam reg_word_e PW = (n < GRP) ? W_POL_LO : W_POL_HI;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 pol_q[n] <= 1'b0;
            else if (wr && word == PW)  pol_q[n] <= bus_wdata[BITP];
         end
      end
   endgenerate

   always_comb begin
      pol_lo_view = '0;
      pol_hi_view = '0;
      for (int n = 0; n < NPINS; n++) begin
         if (n < GRP) pol_lo_view[STRIDE*(n%GRP)] = pol_q[n];
         else         pol_hi_view[STRIDE*(n%GRP)] = pol_q[n];
      end
   end

   // ---- per-pin level detectors ----
   assign clr_vec = (wr && word == W_STAT) ? bus_wdata[NPINS-1:0] : '0;

   generate
      for (genvar n = 0; n < NPINS; n++) begin : g_cell
         gpio_lvl_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_in (in_sync[n]),
            .pol_low(pol_q[n]),
            .clr    (clr_vec[n]),
            .stat   (stat[n])
         );
      end
   endgenerate

   // ---- outputs ----
   assign pin_out = dout_q;
   assign pin_oe  = oen_q;
   assign irq     = |(stat & ien_q);

   // ---- read path ----
   always_comb begin
      bus_rdata = '0;
      if (addr_ok) begin
         case (word)
            W_DOUT:   bus_rdata[NPINS-1:0] = dout_q;
            W_OEN:    bus_rdata[NPINS-1:0] = oen_q;
            W_PIN:    bus_rdata[NPINS-1:0] = in_sync;
            W_STAT:   bus_rdata[NPINS-1:0] = stat;
            W_POL_LO: bus_rdata = pol_lo_view;
            W_IEN:    bus_rdata[NPINS-1:0] = ien_q;
            W_POL_HI: bus_rdata = pol_hi_view;
            W_MUX:    bus_rdata = mux_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !bus_we) |=> irq);
   // R2
   oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(pin_oe) && $stable(pin_out)));
   // R10
   bad_addr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_ok |-> (bus_rdata == '0));
endmodule

// File: tb/test_gpio_lvl_ctrl.sv
module test_gpio_lvl_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [11:0] pin_in = '0;
   logic [11:0] pin_out, pin_oe;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   gpio_lvl_ctrl i_gpio_lvl_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   typedef struct packed {
      logic        we;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   // write rows store data; read rows compare against exp and name the requirement
   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0, 4'd2},
      '{1'b0, 8'h00, 32'h0, 32'h0000_0FFF, 4'd2},        // R2
      '{1'b1, 8'h04, 32'h0000_0A5A, 32'h0, 4'd2},
      '{1'b0, 8'h04, 32'h0, 32'h0000_0A5A, 4'd2},        // R2
      '{1'b1, 8'h1C, 32'hDEAD_BEEF, 32'h0, 4'd9},
      '{1'b0, 8'h1C, 32'h0, 32'hDEAD_BEEF, 4'd9},        // R9
      '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 4'd4},
      '{1'b0, 8'h10, 32'h0, 32'h1111_1111, 4'd4},        // R4
      '{1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0, 4'd4},
      '{1'b0, 8'h18, 32'h0, 32'h0000_1111, 4'd4},        // R4
      '{1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0, 4'd10},
      '{1'b0, 8'h20, 32'h0, 32'h0, 4'd10},               // R10
      '{1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0, 4'd8},
      '{1'b0, 8'h14, 32'h0, 32'h0000_0FFF, 4'd8},        // R8
      '{1'b1, 8'h05, 32'h0, 32'h0, 4'd10},
      '{1'b0, 8'h14, 32'h0, 32'h0000_0FFF, 4'd10}        // R10
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1 chk(req, bus_rdata, exp);
   endtask

   task automatic edges(input int k);
      for (int i = 0; i < k; i++) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      for (int a = 0; a < 32; a += 4) rd("R1", 8'(a), 32'h0);
      chk("R1", {31'h0, irq}, 32'h0);
      chk("R1", {20'h0, pin_oe}, 32'h0);
      chk("R1", {20'h0, pin_out}, 32'h0);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v].we) wr(VEC[v].addr, VEC[v].data);
         else rd($sformatf("R%0d", VEC[v].req), VEC[v].addr, VEC[v].exp);
      end
      // R2 and R9: pads follow data/enable, mux write left them alone
      chk("R2", {20'h0, pin_out}, 32'h0000_0FFF);
      chk("R2", {20'h0, pin_oe}, 32'h0000_0A5A);

      // restore and clear statuses set by active-low polarity during the table
      wr(8'h10, 0); wr(8'h18, 0); wr(8'h14, 0); wr(8'h00, 0); wr(8'h04, 0);
      wr(8'h0C, 32'hFFF);
      rd("R6", 8'h0C, 32'h0);
      chk("R8", {31'h0, irq}, 32'h0);

      // R3: two-edge synchroniser
      @(negedge clk) pin_in = 12'h123;
      edges(1);
      rd("R3", 8'h08, 32'h0);
      edges(1);
      rd("R3", 8'h08, 32'h123);
      edges(1);
      rd("R5", 8'h0C, 32'h123);
      // R5: sticky after level goes away
      @(negedge clk) pin_in = 12'h000;
      edges(4);
      rd("R5", 8'h0C, 32'h123);
      // R8: masking
      chk("R8", {31'h0, irq}, 32'h0);
      wr(8'h14, 32'h020);
      chk("R8", {31'h0, irq}, 32'h1);
      wr(8'h14, 32'h004);
      chk("R8", {31'h0, irq}, 32'h0);
      // R6: partial clear
      wr(8'h0C, 32'h001);
      rd("R6", 8'h0C, 32'h122);

      // R7: clear while still active
      wr(8'h14, 32'h020);
      @(negedge clk) pin_in = 12'h020;
      edges(3);
      wr(8'h0C, 32'h020);
      rd("R7", 8'h0C, 32'h102);
      chk("R7", {31'h0, irq}, 32'h0);
      edges(1);
      rd("R7", 8'h0C, 32'h122);
      chk("R7", {31'h0, irq}, 32'h1);

      // R4: active-low polarity for pin 9 and pin 3
      @(negedge clk) pin_in = 12'h000;
      edges(3);
      wr(8'h0C, 32'hFFF);
      rd("R6", 8'h0C, 32'h0);
      wr(8'h18, 32'h0000_0010);
      rd("R4", 8'h0C, 32'h0);
      edges(1);
      rd("R4", 8'h0C, 32'h200);
      wr(8'h10, 32'h0000_1000);
      edges(1);
      rd("R4", 8'h0C, 32'h208);
      rd("R4", 8'h08, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule